// File: doc/BRIEF.md
# Depth Frame Change Skip Detector

This block sits on a raster stream of depth samples and decides, once per frame, whether the frame differs enough from the last frame that was actually processed to be worth processing. The frame is cut into a fixed grid of rectangular tiles. For every tile the block sums the depth samples and compares that sum against the sum stored for the same tile from the last processed frame. A tile counts as changed when the mean depth moved by more than a programmable depth threshold, in either direction. The changed tiles are counted. If the count is at or below a programmable count threshold, the frame is marked for skipping.

The decision comes out as a one-cycle valid pulse together with a registered skip level, the changed-tile count and a per-tile change map. The skip level holds until the next decision, so it can drive a camera frame-rate control directly. The stored tile table is replaced only by frames that are processed. A run of slowly drifting frames is therefore measured against the last frame that went downstream, not against its immediate predecessor.

Top module: `depth_skip_gate`

## Requirements
- R1: A frame starts at a valid sample with `pix_sof` high, and `pix_eol` marks the last sample of each line. Tiles are `TILE_W` x `TILE_H` samples. The tile at tile column tx and tile row ty has index ty*TILES_X+tx, and bit index of `dec_map` equals that tile index.
- R2: A tile is changed when |S_new - S_prev| > cfg_depth_thr * TILE_W * TILE_H, where S is the exact sum of the tile's samples. This means the mean moved strictly more than the threshold, up or down. Equality is not a change.
- R3: `dec_count` equals the number of changed tiles, and it equals the population count of `dec_map`.
- R4: `dec_skip` is 1 when a stored table exists and `dec_count` <= `cfg_count_thr`. Otherwise it is 0, meaning the frame is processed.
- R5: The stored tile sums are replaced by the current frame's sums only when the frame is processed. A skipped frame leaves them untouched.
- R6: The first frame after reset is always processed, and all of its tiles count as changed (`dec_count` = TILES_X*TILES_Y).
- R7: `dec_valid` is high for exactly one cycle per frame. The cycle is the one that starts at the third rising edge, counting the edge that accepts the frame's last sample as the first.
- R8: After reset, `dec_valid`, `dec_skip`, `dec_count` and `dec_map` are 0. `dec_skip` keeps its value between decisions.
- R9: Cycles with `pix_valid` low are ignored. Samples arriving outside a frame (after its last sample and before the next `pix_sof`) are ignored and produce no decision.
- R10: Full-scale 16-bit samples are summed without overflow. The strict comparison of R2 holds at the largest thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Sample present this cycle |
| pix_sof | input | 1 | First sample of a frame |
| pix_eol | input | 1 | Last sample of a line |
| pix_depth | input | DEPTH_W | Depth sample |
| cfg_depth_thr | input | DEPTH_W | Per-tile mean depth change threshold |
| cfg_count_thr | input | CNT_W | Largest changed-tile count that still skips |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_skip | output | 1 | 1 = skip frame, 0 = process; held between decisions |
| dec_count | output | CNT_W | Number of changed tiles in the decided frame |
| dec_map | output | TILES | Change flag per tile, bit = tile index |

## Verification
The assertions take for granted that frames arrive whole and well formed. That means exactly the configured number of samples per line, `pix_eol` on each line's last sample, and no new `pix_sof` inside a frame. They also assume both thresholds stay constant from a frame's first sample until its decision. The stimulus builds every frame from the configured geometry, inserts idle cycles only while `pix_valid` is low, and changes the thresholds only between frames. Stray samples are injected only after a frame has ended, so the out-of-frame path is exercised without breaking these premises.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

  typedef enum logic {
    DEC_PROCESS = 1'b0,
    DEC_SKIP    = 1'b1
  } dec_kind_e;

  // Magnitude of the difference of two unsigned values.
  function automatic logic [63:0] mag_diff(input logic [63:0] a, input logic [63:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/dsg_raster_pos.sv
module dsg_raster_pos #(
  parameter  int TILES_X = 8,
  parameter  int TILES_Y = 8,
  parameter  int TILE_W  = 20,
  parameter  int TILE_H  = 15,
  localparam int TXW     = $clog2(TILES_X > 1 ? TILES_X : 2),
  localparam int IDXW    = $clog2(TILES_X * TILES_Y > 1 ? TILES_X * TILES_Y : 2)
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_valid,
  input  logic            pix_sof,
  input  logic            pix_eol,
  output logic            accept,
  output logic [TXW-1:0]  tile_col,
  output logic [IDXW-1:0] tile_idx,
  output logic            tile_first,
  output logic            tile_last,
  output logic            frame_last
);

  localparam int TYW = $clog2(TILES_Y > 1 ? TILES_Y : 2);
  localparam int LXW = $clog2(TILE_W > 1 ? TILE_W : 2);
  localparam int LYW = $clog2(TILE_H > 1 ? TILE_H : 2);

  localparam logic [LXW-1:0] LX_END = LXW'(TILE_W - 1);
  localparam logic [LYW-1:0] LY_END = LYW'(TILE_H - 1);
  localparam logic [TXW-1:0] TX_END = TXW'(TILES_X - 1);
  localparam logic [TYW-1:0] TY_END = TYW'(TILES_Y - 1);

  logic [LXW-1:0] lx_q, cur_lx;
  logic [LYW-1:0] ly_q, cur_ly;
  logic [TXW-1:0] tx_q, cur_tx;
  logic [TYW-1:0] ty_q, cur_ty;
  logic           in_frame;
  logic           sof_hit;
  logic           lx_end, ly_end, tx_end, ty_end;

  always_comb begin
    sof_hit    = pix_valid && pix_sof;
    accept     = pix_valid && (pix_sof || in_frame);
    cur_lx     = sof_hit ? '0 : lx_q;
    cur_ly     = sof_hit ? '0 : ly_q;
    cur_tx     = sof_hit ? '0 : tx_q;
    cur_ty     = sof_hit ? '0 : ty_q;
    lx_end     = (cur_lx == LX_END);
    ly_end     = (cur_ly == LY_END);
    tx_end     = (cur_tx == TX_END);
    ty_end     = (cur_ty == TY_END);
    tile_col   = cur_tx;
    tile_idx   = IDXW'(cur_ty) * IDXW'(TILES_X) + IDXW'(cur_tx);
    tile_first = (cur_lx == '0) && (cur_ly == '0);
    tile_last  = lx_end && ly_end;
    frame_last = accept && tile_last && tx_end && ty_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lx_q     <= '0;
      ly_q     <= '0;
      tx_q     <= '0;
      ty_q     <= '0;
      in_frame <= 1'b0;
    end else if (accept) begin
      in_frame <= !frame_last;
      if (pix_eol) begin
        lx_q <= '0;
        tx_q <= '0;
        if (ly_end) begin
          ly_q <= '0;
          ty_q <= cur_ty + 1'b1;
        end else begin
          ly_q <= cur_ly + 1'b1;
          ty_q <= cur_ty;
        end
      end else begin
        ly_q <= cur_ly;
        ty_q <= cur_ty;
        if (lx_end) begin
          lx_q <= '0;
          tx_q <= cur_tx + 1'b1;
        end else begin
          lx_q <= cur_lx + 1'b1;
          tx_q <= cur_tx;
        end
      end
    end
  end

endmodule

// File: rtl/dsg_tile_accum.sv
module dsg_tile_accum #(
  parameter int TILES_X = 8,
  parameter int DEPTH_W = 16,
  parameter int SUM_W   = 25,
  parameter int TXW     = 3,
  parameter int IDXW    = 6
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [TXW-1:0]   tile_col,
  input  logic [IDXW-1:0]  tile_idx,
  input  logic             tile_first,
  input  logic             tile_last,
  input  logic             frame_last,
  input  logic [DEPTH_W-1:0] depth,
  output logic             sum_vld,
  output logic [SUM_W-1:0] sum_val,
  output logic [IDXW-1:0]  sum_idx,
  output logic             sum_frame_end
);

  logic [SUM_W-1:0] acc [TILES_X];
  logic [SUM_W-1:0] sum_now;

  assign sum_now = tile_first ? SUM_W'(depth) : (acc[tile_col] + SUM_W'(depth));

  // One running sum per tile column of the current band of lines.
  for (genvar c = 0; c < TILES_X; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (accept && (tile_col == TXW'(c))) begin
        acc[c] <= sum_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_vld       <= 1'b0;
      sum_frame_end <= 1'b0;
      sum_val       <= '0;
      sum_idx       <= '0;
    end else begin
      sum_vld       <= accept && tile_last;
      sum_frame_end <= frame_last;
      sum_val       <= sum_now;
      sum_idx       <= tile_idx;
    end
  end

endmodule

// File: rtl/dsg_tile_store.sv
module dsg_tile_store #(
  parameter int DATA_W = 25,
  parameter int ADDR_W = 7
)(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/dsg_change_judge.sv
module dsg_change_judge
  import dsg_pkg::*;
#(
  parameter int TILES   = 64,
  parameter int PIX     = 300,
  parameter int DEPTH_W = 16,
  parameter int SUM_W   = 25,
  parameter int IDXW    = 6,
  parameter int CNT_W   = 7
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               sum_vld,
  input  logic [SUM_W-1:0]   sum_val,
  input  logic [IDXW-1:0]    sum_idx,
  input  logic               sum_frame_end,
  input  logic [SUM_W-1:0]   prev_sum,
  input  logic [DEPTH_W-1:0] cfg_depth_thr,
  input  logic [CNT_W-1:0]   cfg_count_thr,
  output logic               bank_wr,
  output logic               dec_valid,
  output logic               dec_skip,
  output logic [CNT_W-1:0]   dec_count,
  output logic [TILES-1:0]   dec_map
);

  logic               v1, end1;
  logic [SUM_W-1:0]   sum1;
  logic [IDXW-1:0]    idx1;
  logic               table_ok;
  logic [CNT_W-1:0]   cnt_acc, cnt_next;
  logic [TILES-1:0]   map_acc, map_next, tile_bit;
  logic [SUM_W-1:0]   thr_scaled;
  logic               changed;
  dec_kind_e          verdict;

  // Stage aligned with the registered table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      end1 <= 1'b0;
      sum1 <= '0;
      idx1 <= '0;
    end else begin
      v1   <= sum_vld;
      end1 <= sum_frame_end;
      sum1 <= sum_val;
      idx1 <= sum_idx;
    end
  end

  always_comb begin
    thr_scaled = SUM_W'(cfg_depth_thr) * SUM_W'(PIX);
    changed    = v1 && (!table_ok ||
                 (mag_diff(64'(sum1), 64'(prev_sum)) > 64'(thr_scaled)));
    tile_bit   = TILES'(1) << idx1;
    cnt_next   = cnt_acc + {{(CNT_W-1){1'b0}}, changed};
    map_next   = changed ? (map_acc | tile_bit) : map_acc;
    verdict    = (table_ok && (cnt_next <= cfg_count_thr)) ? DEC_SKIP : DEC_PROCESS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_acc   <= '0;
      map_acc   <= '0;
      table_ok  <= 1'b0;
      bank_wr   <= 1'b0;
      dec_valid <= 1'b0;
      dec_skip  <= 1'b0;
      dec_count <= '0;
      dec_map   <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (v1 && end1) begin
        dec_valid <= 1'b1;
        dec_skip  <= (verdict == DEC_SKIP);
        dec_count <= cnt_next;
        dec_map   <= map_next;
        cnt_acc   <= '0;
        map_acc   <= '0;
        if (verdict == DEC_PROCESS) begin
          table_ok <= 1'b1;
          bank_wr  <= ~bank_wr;
        end
      end else if (v1) begin
        cnt_acc <= cnt_next;
        map_acc <= map_next;
      end
    end
  end

endmodule

// File: rtl/depth_skip_gate.sv
module depth_skip_gate #(
  parameter  int TILES_X = 8,
  parameter  int TILES_Y = 8,
  parameter  int TILE_W  = 20,
  parameter  int TILE_H  = 15,
  parameter  int DEPTH_W = 16,
  localparam int TILES   = TILES_X * TILES_Y,
  localparam int CNT_W   = $clog2(TILES + 1)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_valid,
  input  logic               pix_sof,
  input  logic               pix_eol,
  input  logic [DEPTH_W-1:0] pix_depth,
  input  logic [DEPTH_W-1:0] cfg_depth_thr,
  input  logic [CNT_W-1:0]   cfg_count_thr,
  output logic               dec_valid,
  output logic               dec_skip,
  output logic [CNT_W-1:0]   dec_count,
  output logic [TILES-1:0]   dec_map
);

  localparam int PIX   = TILE_W * TILE_H;
  localparam int SUM_W = DEPTH_W + $clog2(PIX > 1 ? PIX : 2);
  localparam int TXW   = $clog2(TILES_X > 1 ? TILES_X : 2);
  localparam int IDXW  = $clog2(TILES > 1 ? TILES : 2);
  localparam int ADDRW = IDXW + 1;

  logic             accept, tile_first, tile_last, frame_last;
  logic [TXW-1:0]   tile_col;
  logic [IDXW-1:0]  tile_idx;
  logic             sum_vld, sum_frame_end;
  logic [SUM_W-1:0] sum_val, prev_sum;
  logic [IDXW-1:0]  sum_idx;
  logic             bank_wr;

  dsg_raster_pos #(
    .TILES_X(TILES_X), .TILES_Y(TILES_Y), .TILE_W(TILE_W), .TILE_H(TILE_H)
  ) u_pos (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .accept(accept), .tile_col(tile_col), .tile_idx(tile_idx),
    .tile_first(tile_first), .tile_last(tile_last), .frame_last(frame_last)
  );

  dsg_tile_accum #(
    .TILES_X(TILES_X), .DEPTH_W(DEPTH_W), .SUM_W(SUM_W), .TXW(TXW), .IDXW(IDXW)
  ) u_acc (
    .clk(clk), .rst(rst), .accept(accept), .tile_col(tile_col), .tile_idx(tile_idx),
    .tile_first(tile_first), .tile_last(tile_last), .frame_last(frame_last),
    .depth(pix_depth), .sum_vld(sum_vld), .sum_val(sum_val), .sum_idx(sum_idx),
    .sum_frame_end(sum_frame_end)
  );

  // Two banks: one holds the last processed frame, the other collects the current one.
  dsg_tile_store #(
    .DATA_W(SUM_W), .ADDR_W(ADDRW)
  ) u_store (
    .clk(clk),
    .wr_en(sum_vld), .wr_addr({bank_wr, sum_idx}), .wr_data(sum_val),
    .rd_en(sum_vld), .rd_addr({~bank_wr, sum_idx}), .rd_data(prev_sum)
  );

  dsg_change_judge #(
    .TILES(TILES), .PIX(PIX), .DEPTH_W(DEPTH_W), .SUM_W(SUM_W), .IDXW(IDXW), .CNT_W(CNT_W)
  ) u_judge (
    .clk(clk), .rst(rst), .sum_vld(sum_vld), .sum_val(sum_val), .sum_idx(sum_idx),
    .sum_frame_end(sum_frame_end), .prev_sum(prev_sum),
    .cfg_depth_thr(cfg_depth_thr), .cfg_count_thr(cfg_count_thr),
    .bank_wr(bank_wr), .dec_valid(dec_valid), .dec_skip(dec_skip),
    .dec_count(dec_count), .dec_map(dec_map)
  );

endmodule

// File: rtl/dsg_checker.sv
module dsg_checker #(
  parameter int TILES = 64,
  parameter int CNT_W = 7
)(
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic             dec_skip,
  input logic [CNT_W-1:0] dec_count,
  input logic [CNT_W-1:0] cfg_count_thr,
  input logic [TILES-1:0] dec_map
);

  logic seen_dec;

  always_ff @(posedge clk) begin
    if (rst)            seen_dec <= 1'b0;
    else if (dec_valid) seen_dec <= 1'b1;
  end

  // R7: the decision strobe never lasts two cycles
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  // R8: skip level only moves on a decision
  a_r8_skip_held: assert property (@(posedge clk) disable iff (rst)
    (seen_dec && !dec_valid) |-> $stable(dec_skip));

  // R6: first decision after reset processes with every tile changed
  a_r6_first_processed: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !seen_dec) |-> (!dec_skip && (int'(dec_count) == TILES)));

  // R4: skip only at or below the count threshold
  a_r4_skip_bound: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_skip) |-> (dec_count <= $past(cfg_count_thr)));

  // R4: once a table exists, process only above the count threshold
  a_r4_process_bound: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_skip && seen_dec) |-> (dec_count > $past(cfg_count_thr)));

  // R3: count and map agree
  a_r3_map_count: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ($countones(dec_map) == int'(dec_count)));

endmodule

bind depth_skip_gate dsg_checker #(.TILES(TILES), .CNT_W(CNT_W)) u_dsg_checker (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_skip(dec_skip),
  .dec_count(dec_count), .cfg_count_thr(cfg_count_thr), .dec_map(dec_map)
);

// File: tb/depth_skip_gate_bench.sv
module depth_skip_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TX = 8, TY = 8, TW = 3, TH = 2, DW = 16;
  localparam int TILES = TX * TY;
  localparam int CW = $clog2(TILES + 1);
  localparam int PIX = TW * TH;
  localparam int FW = TX * TW, FH = TY * TH;

  typedef struct packed {
    int base; int grain; int nb; int bump; int dthr; int cthr; int gap; int eskip; int ecnt;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1000, 5,  0,   0, 10, 100, 0, 0, 64},
    '{1000, 5,  0,   0, 10,   0, 0, 1,  0},
    '{1000, 5,  3,  50, 10,   3, 1, 1,  3},
    '{1000, 5,  4,  50, 10,   3, 0, 0,  4},
    '{1000, 5,  4,  50, 10,   0, 0, 1,  0},
    '{1000, 5,  4,  60, 10,   0, 1, 1,  0},
    '{1000, 5,  4,  61, 10,   3, 0, 0,  4},
    '{ 900, 5,  0,   0, 20,  10, 1, 0, 64},
    '{ 900, 5, 10, -30, 20,  20, 0, 1, 10}
  };

  logic clk = 1'b0;
  logic rst;
  logic pix_valid, pix_sof, pix_eol;
  logic [DW-1:0] pix_depth, cfg_depth_thr;
  logic [CW-1:0] cfg_count_thr;
  logic dec_valid, dec_skip;
  logic [CW-1:0] dec_count;
  logic [TILES-1:0] dec_map;

  int checks = 0, fails = 0, pulses = 0;
  longint model_prev [TILES];
  bit model_ok = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  depth_skip_gate #(.TILES_X(TX), .TILES_Y(TY), .TILE_W(TW), .TILE_H(TH), .DEPTH_W(DW))
  u_depth_skip_gate (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .pix_depth(pix_depth), .cfg_depth_thr(cfg_depth_thr), .cfg_count_thr(cfg_count_thr),
    .dec_valid(dec_valid), .dec_skip(dec_skip), .dec_count(dec_count), .dec_map(dec_map)
  );

  always @(negedge clk) if (!rst && dec_valid) pulses++;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pix_at(int x, int y, int base, int grain, int nb, int bump);
    int t = (y / TH) * TX + (x / TW);
    return base + (((x % TW) + (y % TH)) % 3) * grain + ((t < nb) ? bump : 0);
  endfunction

  task automatic send_frame(int base, int grain, int nb, int bump, int gap);
    for (int y = 0; y < FH; y++) begin
      for (int x = 0; x < FW; x++) begin
        if (gap != 0 && ((x + y) % 7 == 3)) begin
          @(posedge clk); #1;
          pix_valid = 1'b0;
        end
        @(posedge clk); #1;
        pix_valid = 1'b1;
        pix_sof   = (x == 0 && y == 0);
        pix_eol   = (x == FW - 1);
        pix_depth = DW'(pix_at(x, y, base, grain, nb, bump));
      end
    end
    @(posedge clk); #1;   // edge that accepted the last sample
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
  endtask

  task automatic run_frame(vec_t v, string tag);
    logic [63:0] emap;
    longint nsum [TILES];
    int p0;
    emap = '0;
    for (int t = 0; t < TILES; t++) begin
      longint d;
      nsum[t] = 0;
      for (int ly = 0; ly < TH; ly++)
        for (int lx = 0; lx < TW; lx++)
          nsum[t] += pix_at((t % TX) * TW + lx, (t / TX) * TH + ly, v.base, v.grain, v.nb, v.bump);
      d = (nsum[t] > model_prev[t]) ? nsum[t] - model_prev[t] : model_prev[t] - nsum[t];
      emap[t] = !model_ok || (d > longint'(v.dthr) * PIX);
    end
    cfg_depth_thr = DW'(v.dthr);
    cfg_count_thr = CW'(v.cthr);
    p0 = pulses;
    send_frame(v.base, v.grain, v.nb, v.bump, v.gap);
    @(posedge clk); #1;
    chk(dec_valid == 1'b0, "R7 early strobe", 64'(dec_valid), 0);
    @(posedge clk); #1;
    chk(dec_valid == 1'b1, "R7 strobe", 64'(dec_valid), 1);
    chk(dec_skip == v.eskip[0], tag, 64'(dec_skip), 64'(v.eskip));
    chk(int'(dec_count) == v.ecnt, "R3 count", 64'(dec_count), 64'(v.ecnt));
    chk(dec_map == emap, "R1,R2 map", dec_map, emap);
    @(posedge clk); #1;
    chk(dec_valid == 1'b0, "R7 width", 64'(dec_valid), 0);
    chk(pulses == p0 + 1, "R7 one per frame", 64'(pulses - p0), 1);
    if (v.eskip == 0) begin
      model_prev = nsum;
      model_ok = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    model_ok = 1'b0;
  endtask

  initial begin
    int p0;
    pix_valid = 0; pix_sof = 0; pix_eol = 0; pix_depth = '0;
    cfg_depth_thr = '0; cfg_count_thr = '0;
    for (int t = 0; t < TILES; t++) model_prev[t] = 0;
    #1 do_reset();
    @(posedge clk); #1;
    chk(dec_valid == 0 && dec_skip == 0, "R8 reset strobe/skip", {dec_valid, dec_skip}, 0);
    chk(dec_count == 0 && dec_map == 0, "R8 reset count/map", 64'(dec_count) | dec_map, 0);

    for (int i = 0; i < NVEC; i++)
      run_frame(VECS[i], (i == 0) ? "R6 first" : (i == 4) ? "R5 table update" : "R4 skip");

    // R8: skip level held long after the decision
    repeat (20) @(posedge clk);
    #1 chk(dec_skip == 1'b1, "R8 hold", 64'(dec_skip), 1);

    // R9: stray samples outside a frame
    p0 = pulses;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      pix_valid = 1'b1; pix_sof = 1'b0; pix_eol = (k % FW == FW - 1); pix_depth = 16'd60000;
    end
    @(posedge clk); #1 pix_valid = 1'b0; pix_eol = 1'b0;
    repeat (5) @(posedge clk);
    #1 chk(pulses == p0, "R9 no decision from strays", 64'(pulses - p0), 0);
    run_frame('{900, 5, 0, 0, 20, 0, 0, 1, 0}, "R9 strays ignored");

    // R10: full-scale samples, strict comparison at a large threshold
    run_frame('{65000, 5, 0, 0, 64100, 0, 1, 1, 0}, "R10 equal diff skips");
    run_frame('{65000, 5, 0, 0, 64099, 63, 0, 0, 64}, "R10 one above processes");
    run_frame('{0, 5, 0, 0, 64999, 63, 0, 0, 64}, "R2 downward change");

    // R6: reset mid-run invalidates the table
    do_reset();
    @(posedge clk); #1;
    chk(dec_skip == 0 && dec_count == 0, "R8 reset again", 64'(dec_count), 0);
    run_frame('{0, 5, 0, 0, 0, 100, 0, 0, 64}, "R6 after reset");
    run_frame('{0, 5, 0, 0, 0, 0, 0, 1, 0}, "R5 stored after process");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule